// File: doc/BRIEF.md
# Hashed Reader-Writer Lock Directory

This block serialises near-memory operations against each other. It keeps a table of reader-writer locks. Each lock is chosen by folding the cache-block number of a request's address with XOR into a table index. A requester presents an address and a mode (shared read or exclusive write) on the acquire port. The request is accepted only when the indexed lock can be taken. Until then `acq_ready_o` stays low, and the requester holds its request. When the operation completes, the requester returns the lock through the release port.

The hash loses information, so unrelated blocks can share a lock. Such aliasing only adds waiting and never lets two conflicting operations run together. A release that does not match a held lock sets a sticky error flag and changes nothing in the table. When a release and an acquire hit the same lock in one cycle, the release is applied first, and the acquire is judged against the freed state.

Top module: `rwlock_dir`

## Requirements
- R1: After reset every lock is free, `acq_ready_o` is 1 for any request, and `err_o` and `acq_grant_o` are 0.
- R2: The lock index is the XOR of successive IDX_W-bit chunks of addr[AW-1:6]. Chunk 0 starts at address bit 6, and the last chunk is zero-padded. Addresses that differ only in bits 5:0 use the same lock. Aliasing addresses, such as 0x1000 and 0x21040, contend for one lock.
- R3: A write request (`acq_write_i`=1) is ready only while its lock has neither a writer nor any reader. A granted write holds the lock exclusively.
- R4: A read request (`acq_write_i`=0) is ready while no writer holds the lock, even when other readers hold it, and is refused while a writer holds it.
- R5: The reader count saturates at 2^RD_CNT_W-1 (7 by default). A read request beyond that count is refused until a reader releases.
- R6: `acq_grant_o` is 1 in the cycle after a clock edge at which `acq_valid_i` and `acq_ready_o` were both 1, and 0 otherwise.
- R7: A read release (`rel_write_i`=0) removes one reader, and a write release (`rel_write_i`=1) clears the writer. Once a lock is free, a write to it becomes ready.
- R8: A release whose mode is not held on its lock sets `err_o`. `err_o` stays 1 until reset, and the lock is left unchanged.
- R9: A valid release and an acquire on the same lock in the same cycle are resolved release first, so `acq_ready_o` reflects the lock after the release.
- R10: A request that is not ready is not granted and leaves the table unchanged while it is held, and it is granted in the first cycle its lock allows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acq_valid_i | input | 1 | Acquire request present |
| acq_addr_i | input | AW | Byte address of the acquire |
| acq_write_i | input | 1 | 1 = exclusive write, 0 = shared read |
| acq_ready_o | output | 1 | Lock for the request is available this cycle |
| acq_grant_o | output | 1 | Acquire was accepted on the previous edge |
| rel_valid_i | input | 1 | Release present |
| rel_addr_i | input | AW | Byte address of the release |
| rel_write_i | input | 1 | Mode being released |
| err_o | output | 1 | Sticky flag for an unmatched release |

## Verification
`acq_ready_o` is combinational from the inputs and the lock table. The bench therefore samples it one time unit after it drives the inputs, in the same cycle. Acceptance and release change the table at the next rising edge. `acq_grant_o` and `err_o` are due one register later, in the cycle after that edge. The bench reads them just after the edge and before it drives the next stimulus. Every state change is observed through the readiness of a later request, so each check falls in a known cycle relative to its stimulus.

// File: rtl/rwlock_dir_pkg.sv
package rwlock_dir_pkg;
  typedef enum logic {LK_READ = 1'b0, LK_WRITE = 1'b1} lk_mode_e;
  typedef enum logic {OP_ACQ = 1'b0, OP_REL = 1'b1} lk_op_e;
endpackage

// File: rtl/rwlock_hash.sv
module rwlock_hash #(
  parameter int AW    = 32,
  parameter int OFF_W = 6,
  parameter int IDX_W = 11
) (
  input  logic [AW-1:0]    addr_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam int BLK_W = AW - OFF_W;
  localparam int NCH   = (BLK_W + IDX_W - 1) / IDX_W;
  localparam int PAD_W = NCH * IDX_W;

  logic [PAD_W-1:0] pad;
  assign pad = PAD_W'(addr_i[AW-1:OFF_W]);

  always_comb begin
    idx_o = '0;
    for (int c = 0; c < NCH; c++) idx_o ^= pad[c*IDX_W +: IDX_W];
  end
endmodule

// File: rtl/rwlock_update.sv
module rwlock_update
  import rwlock_dir_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  lk_op_e           op_i,
  input  lk_mode_e         mode_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             ok_o,
  output logic             wr_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_comb begin
    ok_o  = 1'b0;
    wr_o  = wr_i;
    cnt_o = cnt_i;
    unique case ({op_i, mode_i})
      {OP_ACQ, LK_READ}: begin
        ok_o = !wr_i && (cnt_i != CNT_MAX);
        if (ok_o) cnt_o = cnt_i + 1'b1;
      end
      {OP_ACQ, LK_WRITE}: begin
        ok_o = !wr_i && (cnt_i == '0);
        if (ok_o) wr_o = 1'b1;
      end
      {OP_REL, LK_READ}: begin
        ok_o = (cnt_i != '0);
        if (ok_o) cnt_o = cnt_i - 1'b1;
      end
      default: begin
        ok_o = wr_i;
        if (ok_o) wr_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/rwlock_dir.sv
module rwlock_dir
  import rwlock_dir_pkg::*;
#(
  parameter int AW       = 32,
  parameter int OFF_W    = 6,
  parameter int N        = 2048,
  parameter int RD_CNT_W = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acq_valid_i,
  input  logic [AW-1:0] acq_addr_i,
  input  logic          acq_write_i,
  output logic          acq_ready_o,
  output logic          acq_grant_o,
  input  logic          rel_valid_i,
  input  logic [AW-1:0] rel_addr_i,
  input  logic          rel_write_i,
  output logic          err_o
);
  localparam int IDX_W = $clog2(N);

  logic [N-1:0]          wr_q;
  logic [RD_CNT_W-1:0]   cnt_q [N];
  logic [IDX_W-1:0]      acq_idx, rel_idx;
  logic                  rel_ok, rel_wr_nx, acq_ok, acq_wr_nx;
  logic [RD_CNT_W-1:0]   rel_cnt_nx, acq_cnt_nx;
  logic                  rel_apply, same_idx, acq_fire;
  logic                  acq_wr_base;
  logic [RD_CNT_W-1:0]   acq_cnt_base;
  logic                  err_q, grant_q;

  rwlock_hash #(.AW(AW), .OFF_W(OFF_W), .IDX_W(IDX_W)) i_hash_acq (
    .addr_i(acq_addr_i), .idx_o(acq_idx));
  rwlock_hash #(.AW(AW), .OFF_W(OFF_W), .IDX_W(IDX_W)) i_hash_rel (
    .addr_i(rel_addr_i), .idx_o(rel_idx));

  rwlock_update #(.CNT_W(RD_CNT_W)) i_upd_rel (
    .op_i(OP_REL), .mode_i(lk_mode_e'(rel_write_i)),
    .wr_i(wr_q[rel_idx]), .cnt_i(cnt_q[rel_idx]),
    .ok_o(rel_ok), .wr_o(rel_wr_nx), .cnt_o(rel_cnt_nx));

  assign rel_apply = rel_valid_i && rel_ok;
  assign same_idx  = rel_apply && (rel_idx == acq_idx);

  // release is seen first by an acquire on the same lock
  assign acq_wr_base  = same_idx ? rel_wr_nx  : wr_q[acq_idx];
  assign acq_cnt_base = same_idx ? rel_cnt_nx : cnt_q[acq_idx];

  rwlock_update #(.CNT_W(RD_CNT_W)) i_upd_acq (
    .op_i(OP_ACQ), .mode_i(lk_mode_e'(acq_write_i)),
    .wr_i(acq_wr_base), .cnt_i(acq_cnt_base),
    .ok_o(acq_ok), .wr_o(acq_wr_nx), .cnt_o(acq_cnt_nx));

  assign acq_ready_o = acq_ok;
  assign acq_fire    = acq_valid_i && acq_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0;
      for (int i = 0; i < N; i++) cnt_q[i] <= '0;
    end else begin
      if (rel_apply) begin
        wr_q[rel_idx]  <= rel_wr_nx;
        cnt_q[rel_idx] <= rel_cnt_nx;
      end
      if (acq_fire) begin
        wr_q[acq_idx]  <= acq_wr_nx;
        cnt_q[acq_idx] <= acq_cnt_nx;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q   <= 1'b0;
      grant_q <= 1'b0;
    end else begin
      err_q   <= err_q || (rel_valid_i && !rel_ok);
      grant_q <= acq_fire;
    end
  end

  assign err_o       = err_q;
  assign acq_grant_o = grant_q;

  // R3
  wr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acq_fire && acq_write_i |=> wr_q[$past(acq_idx)] && cnt_q[$past(acq_idx)] == '0);
  // R3
  no_mixed_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_q[acq_idx] |-> cnt_q[acq_idx] == '0);
  // R5
  no_cnt_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acq_fire && !acq_write_i |=> cnt_q[$past(acq_idx)] != '0);
  // R8
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  // R8
  bad_rel_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_valid_i && !rel_ok && !(acq_fire && acq_idx == rel_idx)
    |=> wr_q[$past(rel_idx)] == $past(wr_q[rel_idx])
        && cnt_q[$past(rel_idx)] == $past(cnt_q[rel_idx]));
  // R6
  grant_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acq_grant_o |-> $past(acq_valid_i));
endmodule

// File: tb/test_rwlock_dir.sv
module test_rwlock_dir;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        acq_valid_i = 1'b0, acq_write_i = 1'b0;
  logic [31:0] acq_addr_i = '0, rel_addr_i = '0;
  logic        rel_valid_i = 1'b0, rel_write_i = 1'b0;
  logic        acq_ready_o, acq_grant_o, err_o;
  int          errors = 0, checks = 0;

  always #5 clk_i = ~clk_i;

  rwlock_dir i_rwlock_dir (.*);

  typedef struct packed {
    logic        av;
    logic [31:0] aa;
    logic        aw;
    logic        rv;
    logic [31:0] ra;
    logic        rw;
    logic        rdy;
    logic        err;
    logic [3:0]  req;
  } vec_t;

  // A=0x1000 idx 0x040; 0x1008 same block; C=0x21040 aliases A; D=0x2000
  localparam vec_t VEC [13] = '{
    '{1'b1, 32'h1000,  1'b0, 1'b0, 32'h0,    1'b0, 1'b1, 1'b0, 4'd1},  // R1
    '{1'b1, 32'h1008,  1'b0, 1'b0, 32'h0,    1'b0, 1'b1, 1'b0, 4'd4},  // R4
    '{1'b1, 32'h1000,  1'b1, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0, 4'd3},  // R3
    '{1'b1, 32'h21040, 1'b1, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0, 4'd2},  // R2
    '{1'b1, 32'h2000,  1'b1, 1'b0, 32'h0,    1'b0, 1'b1, 1'b0, 4'd2},  // R2
    '{1'b1, 32'h2000,  1'b0, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0, 4'd4},  // R4
    '{1'b0, 32'h0,     1'b0, 1'b1, 32'h1000, 1'b0, 1'b0, 1'b0, 4'd7},  // R7
    '{1'b0, 32'h0,     1'b0, 1'b1, 32'h1000, 1'b0, 1'b0, 1'b0, 4'd7},  // R7
    '{1'b1, 32'h1000,  1'b1, 1'b0, 32'h0,    1'b0, 1'b1, 1'b0, 4'd7},  // R7
    '{1'b0, 32'h0,     1'b0, 1'b1, 32'h1000, 1'b0, 1'b0, 1'b1, 4'd8},  // R8
    '{1'b1, 32'h21040, 1'b1, 1'b0, 32'h0,    1'b0, 1'b0, 1'b1, 4'd8},  // R8
    '{1'b1, 32'h21040, 1'b1, 1'b1, 32'h1000, 1'b1, 1'b1, 1'b1, 4'd9},  // R9
    '{1'b1, 32'h2000,  1'b0, 1'b1, 32'h2000, 1'b1, 1'b1, 1'b1, 4'd9}   // R9
  };

  task automatic chk(input string tag, input string what, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic av, input logic [31:0] aa, input logic aw,
                      input logic rv, input logic [31:0] ra, input logic rw,
                      input logic rdy, input logic er, input string tag);
    acq_valid_i = av; acq_addr_i = aa; acq_write_i = aw;
    rel_valid_i = rv; rel_addr_i = ra; rel_write_i = rw;
    #1;
    if (av) chk(tag, "ready", acq_ready_o, rdy);
    @(posedge clk_i); #1;
    chk(tag, "grant", acq_grant_o, av & rdy);
    chk(tag, "err", err_o, er);
    acq_valid_i = 1'b0; rel_valid_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    acq_valid_i = 1'b1; acq_addr_i = 32'h4000; acq_write_i = 1'b1;
    #1;
    chk("R1", "ready", acq_ready_o, 1'b1);
    chk("R1", "err", err_o, 1'b0);
    chk("R1", "grant", acq_grant_o, 1'b0);
    acq_valid_i = 1'b0;

    for (int i = 0; i < 13; i++)
      step(VEC[i].av, VEC[i].aa, VEC[i].aw, VEC[i].rv, VEC[i].ra, VEC[i].rw,
           VEC[i].rdy, VEC[i].err, $sformatf("R%0d", VEC[i].req));

    do_reset();
    // R5 saturation at 7 readers
    for (int i = 0; i < 7; i++)
      step(1'b1, 32'h8000, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0, "R5");
    step(1'b1, 32'h8000, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, "R5");
    // R2 offset bits ignored: same lock, still saturated
    step(1'b1, 32'h803F, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, "R2");
    // R9 release frees a slot for a same-cycle read
    step(1'b1, 32'h8000, 1'b0, 1'b1, 32'h8000, 1'b0, 1'b1, 1'b0, "R9");
    // R10 write held off while readers drain, granted on the last release
    for (int i = 0; i < 7; i++)
      step(1'b1, 32'h8000, 1'b1, 1'b1, 32'h8000, 1'b0, (i == 6), 1'b0, "R10");
    // R3 writer now holds: read refused
    step(1'b1, 32'h8000, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, "R3");
    // R8 unmatched read release on a write-held lock
    step(1'b0, 32'h0, 1'b0, 1'b1, 32'h8000, 1'b0, 1'b0, 1'b1, "R8");
    step(1'b1, 32'h8000, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, "R8");
    // R7 write release frees the lock
    step(1'b0, 32'h0, 1'b0, 1'b1, 32'h8000, 1'b1, 1'b0, 1'b1, "R7");
    step(1'b1, 32'h8000, 1'b1, 1'b0, 32'h0, 1'b0, 1'b1, 1'b1, "R7");
    // R6 no grant without valid
    step(1'b0, 32'h8000, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, "R6");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule